// File: doc/BRIEF.md
# Interrupt Priority Resolution Unit

This unit sits next to a processor core's sequencer and decides which pending interrupt request is taken at the next instruction boundary. Two kinds of source feed it. Special sources have a rank fixed in hardware: a reset request, a watchdog or oscillation-stop event, a single-step trap and an address-match trap. Maskable peripheral sources each carry a 3-bit level that software programs. A request pulse is latched as pending. When the core raises its boundary strobe, the unit picks one winner. The next cycle it issues a one-cycle accept pulse with the winner's source code and level.

Peripheral requests only compete when interrupts are globally enabled and their level is above the core's current threshold. Ties between peripherals at the same level go to the lower source index. When the core takes the winner, it returns a one-cycle acknowledge, and only the winner's pending bit is cleared. Every other pending request stays latched and is arbitrated again at a later boundary. A software interrupt instruction skips arbitration altogether and is reported directly. Vector fetch, context stacking and return from an interrupt belong to the core.

Top module: `irq_prio_resolver`

## Requirements
- R1: A pending reset request wins every boundary, even when the global enable is 0 and the threshold is 7. It reports source code 0 and level 7.
- R2: Among pending sources the fixed order is: reset (code 0), then watchdog (code 1, level 7), then any eligible peripheral, then single-step (code N+2, level 0), then address-match (code N+3, level 0). The special sources are never masked by the enable or the threshold.
- R3: Among eligible peripherals, the one with the highest 3-bit level wins. Peripheral i reports source code 2+i and its own level.
- R4: Eligible peripherals that share the highest level are ordered by index, and the lowest index wins.
- R5: A peripheral is eligible only when its pending bit is set, the global enable is 1, and its level is strictly greater than the 3-bit threshold. A level of 0 is therefore never eligible.
- R6: Arbitration happens only on the cycle the boundary strobe is high. The accept output is high for exactly the one cycle after that strobe, and only when some source is eligible. The source code and level are valid with accept and are held until the next accept.
- R7: A one-cycle acknowledge after an accept clears the pending bit of that winner only. The other pending requests stay latched and win later boundaries in priority order.
- R8: A software interrupt strobe produces an accept on the next cycle with source code N+4 and level 0. On that cycle the strobe overrides any boundary, and it neither reads nor changes the pending bits.
- R9: A single-cycle request pulse stays pending over any number of cycles until it is accepted and acknowledged. If a set and a clear of the same bit arrive together, the set wins.
- R10: The active-low synchronous reset clears all pending bits and drives accept, source code and level to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req | input | 1 | Reset-request source pulse |
| wdt_req | input | 1 | Watchdog / oscillation-stop source pulse |
| per_req | input | N | Peripheral request pulses, one per source |
| per_lvl | input | N*3 | Peripheral levels; source i uses bits [3i+2:3i] |
| step_req | input | 1 | Single-step trap pulse |
| amatch_req | input | 1 | Address-match trap pulse |
| cpu_ipl | input | 3 | Current processor priority threshold |
| cpu_ie | input | 1 | Global maskable-interrupt enable |
| boundary | input | 1 | Instruction-boundary strobe, one cycle |
| swi | input | 1 | Software interrupt instruction strobe |
| ack | input | 1 | Acknowledge of the last accepted winner |
| accept | output | 1 | One-cycle accept pulse |
| win_src | output | clog2(N+5) | Winning source code |
| win_lvl | output | 3 | Winning level |

## Verification
The assertions assume a particular handshake from the core. Boundary and software strobes are single-cycle pulses, spaced at least two cycles apart. The acknowledge arrives at most once per accept and before the next boundary, and it never shares a cycle with a boundary. The bench keeps to this handshake. Each scenario raises its requests, waits a cycle, issues one boundary, checks the result, and then sends the acknowledge in the cycle after the accept. Levels, threshold and enable are set before the requests are raised and stay fixed across each boundary.

// File: rtl/irq_prio_pkg.sv
// Package: shared level type and fixed source-code layout for the
// interrupt priority resolver. Assumes 3-bit levels throughout.
package irq_prio_pkg;
    localparam int LVL_W    = 3;
    localparam int SRC_RST  = 0;
    localparam int SRC_WDT  = 1;
    localparam int PER_BASE = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_TOP  = '1;
    localparam lvl_t LVL_NONE = '0;

    // Code of the single-step source for n peripherals
    function automatic int src_step(input int n);
        return n + PER_BASE;
    endfunction

    // Code of the address-match source for n peripherals
    function automatic int src_amatch(input int n);
        return n + PER_BASE + 1;
    endfunction

    // Code reported for a software interrupt for n peripherals
    function automatic int src_swi(input int n);
        return n + PER_BASE + 2;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
// Module: bank of pending-request latches, one bit per source.
// Each bit is set by a request pulse and cleared by a one-hot clear.
// A set and a clear on the same bit in one cycle leave the bit set.
// Assumes synchronous active-low reset.
module irq_pend_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            // Hold one request until it is cleared; set has priority
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[g] <= 1'b0;
                else if (set[g])
                    pend[g] <= 1'b1;
                else if (clr[g])
                    pend[g] <= 1'b0;
            end
        end
    endgenerate

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|$past(set))) |-> ((pend & $past(set)) == $past(set))); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|$past(clr))) |-> ((pend & $past(clr) & ~$past(set)) == '0)); // R7
endmodule

// File: rtl/irq_lvl_pick.sv
// Module: selects among pending peripheral requests the eligible one with
// the highest level; on equal levels the lowest index is chosen.
// Eligibility needs global enable and a level above the threshold.
// Purely combinational; the clock is used only by the assertions.
module irq_lvl_pick
    import irq_prio_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend,
    input  logic [N*LVL_W-1:0] lvl_flat,
    input  lvl_t             ipl,
    input  logic             ie,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output lvl_t             lvl
);
    logic [N-1:0] elig;

    // Mark which peripherals may compete this cycle
    always_comb begin
        for (int i = 0; i < N; i++) begin
            elig[i] = pend[i] && ie
                   && (lvl_flat[i*LVL_W +: LVL_W] != LVL_NONE)
                   && (lvl_flat[i*LVL_W +: LVL_W] > ipl);
        end
    end

    // Scan from the top index down so equal levels fall to the lower index
    always_comb begin
        any = 1'b0;
        idx = '0;
        lvl = LVL_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (!any || lvl_flat[i*LVL_W +: LVL_W] >= lvl)) begin
                any = 1'b1;
                idx = IDX_W'(i);
                lvl = lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end

    AST_PICK_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (ie && (lvl > ipl) && pend[idx])); // R5
endmodule

// File: rtl/irq_prio_resolver.sv
// Module: top of the interrupt priority resolver. Latches requests, merges
// fixed-rank special sources with level-ranked peripherals, reports the
// winner one cycle after an instruction boundary, and clears its pending
// bit on acknowledge. Software interrupts bypass arbitration.
// Assumes boundary/swi are one-cycle pulses at least two cycles apart and
// that ack comes once per accept, before the next boundary.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int N = 8,
    localparam int NSRC  = N + 4,
    localparam int SRC_W = $clog2(N + 5),
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic               wdt_req,
    input  logic [N-1:0]       per_req,
    input  logic [N*LVL_W-1:0] per_lvl,
    input  logic               step_req,
    input  logic               amatch_req,
    input  logic [LVL_W-1:0]   cpu_ipl,
    input  logic               cpu_ie,
    input  logic               boundary,
    input  logic               swi,
    input  logic               ack,
    output logic               accept,
    output logic [SRC_W-1:0]   win_src,
    output logic [LVL_W-1:0]   win_lvl
);
    localparam int STEP_BIT = src_step(N);
    localparam int AM_BIT   = src_amatch(N);
    localparam logic [SRC_W-1:0] SWI_CODE = SRC_W'(src_swi(N));

    logic [NSRC-1:0]  set_v, clr_v, pend;
    logic             per_any;
    logic [IDX_W-1:0] per_idx;
    lvl_t             per_best;
    logic             held;
    logic             found;
    logic [SRC_W-1:0] nxt_src;
    lvl_t             nxt_lvl;

    assign set_v = {amatch_req, step_req, per_req, wdt_req, rst_req};

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_clr
            assign clr_v[g] = held && ack && (win_src == SRC_W'(g));
        end
    endgenerate

    irq_pend_bank #(.W(NSRC)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_v),
        .clr  (clr_v),
        .pend (pend)
    );

    irq_lvl_pick #(.N(N)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend[PER_BASE +: N]),
        .lvl_flat(per_lvl),
        .ipl     (cpu_ipl),
        .ie      (cpu_ie),
        .any     (per_any),
        .idx     (per_idx),
        .lvl     (per_best)
    );

    // Merge fixed-rank special sources around the peripheral winner
    always_comb begin
        found   = 1'b1;
        nxt_src = '0;
        nxt_lvl = LVL_NONE;
        if (pend[SRC_RST]) begin
            nxt_src = SRC_W'(SRC_RST);
            nxt_lvl = LVL_TOP;
        end else if (pend[SRC_WDT]) begin
            nxt_src = SRC_W'(SRC_WDT);
            nxt_lvl = LVL_TOP;
        end else if (per_any) begin
            nxt_src = SRC_W'(PER_BASE) + SRC_W'(per_idx);
            nxt_lvl = per_best;
        end else if (pend[STEP_BIT]) begin
            nxt_src = SRC_W'(STEP_BIT);
        end else if (pend[AM_BIT]) begin
            nxt_src = SRC_W'(AM_BIT);
        end else begin
            found = 1'b0;
        end
    end

    // Register the accept pulse, the winner, and whether an ack is owed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept  <= 1'b0;
            win_src <= '0;
            win_lvl <= '0;
            held    <= 1'b0;
        end else begin
            accept <= 1'b0;
            if (swi) begin
                accept  <= 1'b1;
                win_src <= SWI_CODE;
                win_lvl <= LVL_NONE;
                held    <= 1'b0;
            end else if (boundary && found) begin
                accept  <= 1'b1;
                win_src <= nxt_src;
                win_lvl <= nxt_lvl;
                held    <= 1'b1;
            end else if (ack) begin
                held    <= 1'b0;
            end
        end
    end

    AST_ACCEPT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(rst_n) && $past(boundary || swi))); // R6

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !swi && pend[SRC_RST]) |=> (accept && win_src == '0 && win_lvl == LVL_TOP)); // R1

    AST_WDT_OVER_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !swi && !pend[SRC_RST] && pend[SRC_WDT]) |=> (accept && win_src == SRC_W'(SRC_WDT))); // R2

    AST_SWI_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        swi |=> (accept && win_src == SWI_CODE && win_lvl == LVL_NONE)); // R8

    AST_PERIPH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_src >= SRC_W'(PER_BASE) && win_src < SRC_W'(STEP_BIT))
            |-> (win_lvl > $past(cpu_ipl) && $past(cpu_ie))); // R5
endmodule

// File: tb/irq_prio_resolver_bench.sv
// Directed bench for irq_prio_resolver; one task per scenario.
module irq_prio_resolver_bench;
    localparam int N        = 8;
    localparam int SW       = $clog2(N + 5);
    localparam int C_STEP   = N + 2;
    localparam int C_AM     = N + 3;
    localparam int C_SWI    = N + 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           rst_req, wdt_req, step_req, amatch_req;
    logic [N-1:0]   per_req;
    logic [N*3-1:0] per_lvl;
    logic [2:0]     cpu_ipl;
    logic           cpu_ie, boundary, swi, ack;
    logic           accept;
    logic [SW-1:0]  win_src;
    logic [2:0]     win_lvl;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    irq_prio_resolver #(.N(N)) u_irq_prio_resolver (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .wdt_req(wdt_req),
        .per_req(per_req), .per_lvl(per_lvl), .step_req(step_req),
        .amatch_req(amatch_req), .cpu_ipl(cpu_ipl), .cpu_ie(cpu_ie),
        .boundary(boundary), .swi(swi), .ack(ack), .accept(accept),
        .win_src(win_src), .win_lvl(win_lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rst_req = 0; wdt_req = 0; step_req = 0; amatch_req = 0;
        per_req = '0; per_lvl = '0; cpu_ipl = 3'd0; cpu_ie = 1'b1;
        boundary = 0; swi = 0; ack = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_lvl(input int i, input int v);
        per_lvl[i*3 +: 3] = 3'(v);
    endtask

    // One-cycle request pulse, then one idle cycle
    task automatic raise(input logic r, input logic w, input logic [N-1:0] p,
                         input logic s, input logic a);
        rst_req = r; wdt_req = w; per_req = p; step_req = s; amatch_req = a;
        @(negedge clk);
        rst_req = 0; wdt_req = 0; per_req = '0; step_req = 0; amatch_req = 0;
        @(negedge clk);
    endtask

    // Boundary, check outcome, acknowledge a winner, check pulse ended
    task automatic bnd(input int e_acc, input int e_src, input int e_lvl, input string req);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        chk(req, int'(accept), e_acc);
        if (e_acc != 0) begin
            chk(req, int'(win_src), e_src);
            chk(req, int'(win_lvl), e_lvl);
            ack = 1'b1;
        end
        @(negedge clk);
        ack = 1'b0;
        chk({req, " pulse"}, int'(accept), 0);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 accept", int'(accept), 0);
        chk("R10 src", int'(win_src), 0);
        chk("R10 lvl", int'(win_lvl), 0);
        bnd(0, 0, 0, "R6 idle boundary");
        set_lvl(2, 4);
        raise(0, 1, 8'b0000_0100, 0, 0);
        do_reset();
        set_lvl(2, 4);
        bnd(0, 0, 0, "R10 pending cleared");
    endtask

    task automatic t_latch();
        do_reset();
        set_lvl(3, 5);
        raise(0, 0, 8'b0000_1000, 0, 0);
        for (int k = 0; k < 5; k++) begin
            chk("R6 no boundary no accept", int'(accept), 0);
            @(negedge clk);
        end
        bnd(1, 5, 5, "R9 latched request");
        bnd(0, 0, 0, "R7 cleared after ack");
    endtask

    task automatic t_levels();
        do_reset();
        set_lvl(1, 2); set_lvl(6, 6);
        raise(0, 0, 8'b0100_0010, 0, 0);
        bnd(1, 8, 6, "R3 higher level");
        bnd(1, 3, 2, "R7 loser stays pending");
        bnd(0, 0, 0, "R7 all cleared");
    endtask

    task automatic t_tie();
        do_reset();
        set_lvl(2, 4); set_lvl(5, 4);
        raise(0, 0, 8'b0010_0100, 0, 0);
        bnd(1, 4, 4, "R4 lower index");
        bnd(1, 7, 4, "R4 second of tie");
    endtask

    task automatic t_mask();
        do_reset();
        set_lvl(0, 3); set_lvl(4, 0);
        raise(0, 0, 8'b0001_0001, 0, 0);
        cpu_ie = 1'b0;
        bnd(0, 0, 0, "R5 enable off");
        cpu_ie = 1'b1; cpu_ipl = 3'd3;
        bnd(0, 0, 0, "R5 level equal threshold");
        cpu_ipl = 3'd2;
        bnd(1, 2, 3, "R5 level above threshold");
        cpu_ipl = 3'd0;
        bnd(0, 0, 0, "R5 level zero never");
    endtask

    task automatic t_fixed();
        do_reset();
        set_lvl(7, 1);
        raise(0, 1, 8'b1000_0000, 1, 1);
        bnd(1, 1, 7, "R2 watchdog first");
        bnd(1, 9, 1, "R2 peripheral next");
        bnd(1, C_STEP, 0, "R2 single-step next");
        bnd(1, C_AM, 0, "R2 address match last");
        set_lvl(7, 7);
        raise(0, 0, 8'b1000_0000, 1, 0);
        cpu_ie = 1'b0;
        bnd(1, C_STEP, 0, "R2 step unmasked");
    endtask

    task automatic t_reset_src();
        do_reset();
        set_lvl(0, 7);
        raise(1, 1, 8'b0000_0001, 0, 0);
        cpu_ie = 1'b0; cpu_ipl = 3'd7;
        bnd(1, 0, 7, "R1 reset wins");
        bnd(1, 1, 7, "R1 then watchdog");
    endtask

    task automatic t_swi();
        do_reset();
        set_lvl(1, 5);
        raise(0, 0, 8'b0000_0010, 0, 0);
        swi = 1'b1; boundary = 1'b1;
        @(negedge clk);
        swi = 1'b0; boundary = 1'b0;
        chk("R8 swi accept", int'(accept), 1);
        chk("R8 swi src", int'(win_src), C_SWI);
        chk("R8 swi lvl", int'(win_lvl), 0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        bnd(1, 3, 5, "R8 pending untouched");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R6: watchdog expired, actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_latch();
        t_levels();
        t_tie();
        t_mask();
        t_fixed();
        t_reset_src();
        t_swi();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule